// File: doc/BRIEF.md
# Branch Squash and Redirect Controller

This block steers instruction fetch in a five-stage in-order pipeline and recovers it when a branch-if-equal was guessed wrong. Fetch runs ahead on the sequential path on the guess that every branch falls through. The decoder reports whether the instruction in the fetch/decode register is a branch, and gives its offset. The execute stage reports whether the two operands were equal. The controller forms the branch target in execute and carries the taken flag and target one register further. While the branch sits in the memory stage, the controller steers the fetch PC to the target.

On that same clock edge it clears the valid bits of the three instructions behind the branch. These are the instruction being fetched, the one in decode and the one in execute. Because their valid bits are cleared, none of them reaches writeback or touches architectural state. A stall request freezes the front of the pipeline and drops a bubble into the memory stage. When a stall and a redirect arrive together, the redirect wins.

Two counters let the cycle cost of a program be checked from outside. One counts instructions that reach writeback. The other counts valid instructions thrown away by squashes.

Top module: `bsq_redirect_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the fetch PC is 0, all four stage valid bits are 0 and both counters are 0.
- R2: With fetch requested, no stall and no redirect, `pc_sel_o` is 0 (sequential) and after the clock edge the PC is one higher and the fetch/decode valid bit (`stage_vld_o` bit 0) is set.
- R3: The branch target is the branch's own word address plus 1 plus the sign-extended 8-bit offset, modulo 2^16. It appears on `ex_target_o` while the branch is in execute and on `redirect_pc_o` while it is in the memory stage.
- R4: A branch in the memory stage whose equality test was true drives `redirect_o` high, `squash_o` to 3'b111 (bit 0 fetch/decode, bit 1 decode/execute, bit 2 execute/memory) and `pc_sel_o` to 2 for one cycle. After that edge the PC holds the target, bits 0 to 2 of `stage_vld_o` are 0 and the branch itself is valid in bit 3 (memory/writeback).
- R5: A branch whose equality test was false causes no redirect and no lost instruction. A three-instruction program headed by such a branch, fetched on three consecutive edges from the first edge after reset, shows a commit count of 2 after the sixth edge and 3 after the seventh.
- R6: Squashed instructions never reach writeback. A taken branch followed by two target-path instructions, fetched on the two edges after the redirect, completes its third commit three edges later than the not-taken case.
- R7: A stall request without a redirect sets `pc_sel_o` to 1 and holds the PC and the fetch/decode and decode/execute registers. The execute/memory valid bit is 0 after the edge.
- R8: When a redirect and a stall request occur in the same cycle, the redirect takes effect exactly as in R4.
- R9: `commit_cnt_o` rises by one for each valid instruction leaving writeback. `lost_cnt_o` rises on a redirect by the number of valid instructions squashed, counting the fetch request in that cycle, and is otherwise unchanged.
- R10: With no fetch request and no stall, `pc_sel_o` is 1, the PC holds and no valid instruction enters fetch/decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req_i | input | 1 | Fetch the instruction at the current PC this cycle |
| stall_i | input | 1 | Hold the front of the pipeline this cycle |
| dec_beq_i | input | 1 | Instruction in fetch/decode is a branch-if-equal |
| dec_off_i | input | 8 | Signed branch offset of the instruction in fetch/decode |
| ex_equal_i | input | 1 | Operand equality result for the instruction in execute |
| pc_o | output | 16 | Current fetch PC (word address) |
| pc_sel_o | output | 2 | Fetch PC mux select: 0 sequential, 1 hold, 2 redirect |
| redirect_o | output | 1 | PC is being redirected to the branch target this cycle |
| redirect_pc_o | output | 16 | Target carried by the branch in the memory stage |
| squash_o | output | 3 | Per-stage squash: bit 0 fetch/decode, bit 1 decode/execute, bit 2 execute/memory |
| ex_target_o | output | 16 | Target computed for the instruction in execute |
| stage_vld_o | output | 4 | Valid bits: bit 0 IF/ID, 1 ID/EX, 2 EX/MEM, 3 MEM/WB |
| commit_cnt_o | output | 32 | Instructions completed through writeback |
| lost_cnt_o | output | 32 | Valid instructions discarded by squashes |

## Verification
The assertions check the per-edge rules on every cycle. The PC steps by one on a plain fetch, lands on the carried target after a redirect and holds under a stall or idle. The three younger valid bits clear on the squash edge while the branch survives, a redirect never lasts two cycles, and the lost counter moves only on a redirect. Other properties span a whole program rather than one edge: the 7-cycle fill-and-drain total, the three-cycle penalty of a taken branch, target arithmetic with negative offsets and the exact stall bubble pattern. Only the bench's directed scenarios can show those, by counting edges against the commit counter.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Fetch PC mux select encoding
  typedef enum logic [1:0] {
    PCSEL_SEQ   = 2'd0,
    PCSEL_HOLD  = 2'd1,
    PCSEL_REDIR = 2'd2
  } pcsel_e;

  // Stage positions in the valid vector
  localparam int STG_IFID  = 0;
  localparam int STG_IDEX  = 1;
  localparam int STG_EXMEM = 2;
  localparam int STG_MEMWB = 3;
  localparam int N_STAGE   = 4;
  localparam int N_SQUASH  = 3;

endpackage

// File: rtl/bsq_fetch_ctl.sv
module bsq_fetch_ctl
  import bsq_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_req,
  input  logic            stall,
  input  logic            redirect,
  input  logic [PC_W-1:0] redirect_pc,
  output logic [PC_W-1:0] pc,
  output pcsel_e          pc_sel,
  output logic            fetch_fire
);

  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] cur);
    return cur + PC_W'(1);
  endfunction

  logic [PC_W-1:0] pc_next;

  always_comb begin
    if (redirect)                 pc_sel = PCSEL_REDIR;
    else if (stall || !fetch_req) pc_sel = PCSEL_HOLD;
    else                          pc_sel = PCSEL_SEQ;
  end

  always_comb begin
    unique case (pc_sel)
      PCSEL_REDIR: pc_next = redirect_pc;
      PCSEL_SEQ:   pc_next = seq_next(pc);
      default:     pc_next = pc;
    endcase
  end

  assign fetch_fire = (pc_sel == PCSEL_SEQ);

  always_ff @(posedge clk) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  AST_PC_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !stall && !redirect) |=> (pc == $past(pc) + PC_W'(1))); // R2
  AST_PC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (pc == $past(redirect_pc))); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && (stall || !fetch_req)) |=> $stable(pc)); // R7

endmodule

// File: rtl/bsq_pipe_track.sv
module bsq_pipe_track
  import bsq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_fire,
  input  logic [PC_W-1:0]  fetch_pc,
  input  logic             stall,
  input  logic             redirect,
  input  logic             dec_beq,
  input  logic [OFF_W-1:0] dec_off,
  input  logic             ex_equal,
  output logic [N_STAGE-1:0] vld,
  output logic [PC_W-1:0]  ex_target,
  output logic             mem_taken,
  output logic [PC_W-1:0]  mem_target
);

  // Word-addressed target: own address + 1 + sign-extended offset
  function automatic logic [PC_W-1:0] beq_target(input logic [PC_W-1:0] bpc,
                                                 input logic [OFF_W-1:0] off);
    return bpc + PC_W'(1) + PC_W'($signed(off));
  endfunction

  logic             ifid_v;
  logic [PC_W-1:0]  ifid_pc;
  logic             idex_v;
  logic [PC_W-1:0]  idex_pc;
  logic             idex_beq;
  logic [OFF_W-1:0] idex_off;
  logic             exmem_v;
  logic             exmem_taken;
  logic [PC_W-1:0]  exmem_target;
  logic             memwb_v;
  logic             ex_resolve_taken;

  assign ex_target        = beq_target(idex_pc, idex_off);
  assign ex_resolve_taken = idex_v && idex_beq && ex_equal;

  // IF/ID
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifid_v  <= 1'b0;
      ifid_pc <= '0;
    end else if (redirect) begin
      ifid_v  <= 1'b0;
    end else if (!stall) begin
      ifid_v  <= fetch_fire;
      ifid_pc <= fetch_pc;
    end
  end

  // ID/EX
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idex_v   <= 1'b0;
      idex_pc  <= '0;
      idex_beq <= 1'b0;
      idex_off <= '0;
    end else if (redirect) begin
      idex_v   <= 1'b0;
      idex_beq <= 1'b0;
    end else if (!stall) begin
      idex_v   <= ifid_v;
      idex_pc  <= ifid_pc;
      idex_beq <= ifid_v && dec_beq;
      idex_off <= dec_off;
    end
  end

  // EX/MEM: squash or bubble clears it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exmem_v      <= 1'b0;
      exmem_taken  <= 1'b0;
      exmem_target <= '0;
    end else if (redirect || stall) begin
      exmem_v      <= 1'b0;
      exmem_taken  <= 1'b0;
    end else begin
      exmem_v      <= idex_v;
      exmem_taken  <= ex_resolve_taken;
      exmem_target <= ex_target;
    end
  end

  // MEM/WB: the branch itself always proceeds
  always_ff @(posedge clk) begin
    if (!rst_n) memwb_v <= 1'b0;
    else        memwb_v <= exmem_v;
  end

  assign mem_taken  = exmem_v && exmem_taken;
  assign mem_target = exmem_target;

  assign vld[STG_IFID]  = ifid_v;
  assign vld[STG_IDEX]  = idex_v;
  assign vld[STG_EXMEM] = exmem_v;
  assign vld[STG_MEMWB] = memwb_v;

  AST_SQUASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (!ifid_v && !idex_v && !exmem_v)); // R4
  AST_BRANCH_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> memwb_v); // R4
  AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> (!exmem_v && $stable(ifid_v) && $stable(idex_v) && $stable(ifid_pc))); // R7
  AST_NOT_TAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (idex_v && idex_beq && !ex_equal && !stall && !redirect) |=> !mem_taken); // R5

endmodule

// File: rtl/bsq_perf_cnt.sv
module bsq_perf_cnt #(
  parameter int CNT_W = 32,
  parameter int SQ_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [SQ_W-1:0]  squashed_n,
  output logic [CNT_W-1:0] commit_cnt,
  output logic [CNT_W-1:0] lost_cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_cnt <= '0;
      lost_cnt   <= '0;
    end else begin
      if (commit) commit_cnt <= commit_cnt + CNT_W'(1);
      lost_cnt <= lost_cnt + CNT_W'(squashed_n);
    end
  end

endmodule

// File: rtl/bsq_redirect_ctl.sv
module bsq_redirect_ctl
  import bsq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fetch_req_i,
  input  logic             stall_i,
  input  logic             dec_beq_i,
  input  logic [OFF_W-1:0] dec_off_i,
  input  logic             ex_equal_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [1:0]       pc_sel_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o,
  output logic [2:0]       squash_o,
  output logic [PC_W-1:0]  ex_target_o,
  output logic [3:0]       stage_vld_o,
  output logic [CNT_W-1:0] commit_cnt_o,
  output logic [CNT_W-1:0] lost_cnt_o
);

  localparam int SQ_W = $clog2(N_SQUASH + 1);

  logic               redirect;
  logic [PC_W-1:0]    redirect_pc;
  logic               fetch_fire;
  pcsel_e             pc_sel;
  logic [PC_W-1:0]    pc;
  logic [N_STAGE-1:0] vld;
  logic [SQ_W-1:0]    squashed_n;

  bsq_fetch_ctl #(.PC_W(PC_W)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_req   (fetch_req_i),
    .stall       (stall_i),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .pc          (pc),
    .pc_sel      (pc_sel),
    .fetch_fire  (fetch_fire)
  );

  bsq_pipe_track #(.PC_W(PC_W), .OFF_W(OFF_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_fire (fetch_fire),
    .fetch_pc   (pc),
    .stall      (stall_i),
    .redirect   (redirect),
    .dec_beq    (dec_beq_i),
    .dec_off    (dec_off_i),
    .ex_equal   (ex_equal_i),
    .vld        (vld),
    .ex_target  (ex_target_o),
    .mem_taken  (redirect),
    .mem_target (redirect_pc)
  );

  // Valid instructions thrown away: the one being fetched, decode, execute
  always_comb begin
    squashed_n = '0;
    if (redirect)
      squashed_n = SQ_W'(fetch_req_i) + SQ_W'(vld[STG_IFID]) + SQ_W'(vld[STG_IDEX]);
  end

  bsq_perf_cnt #(.CNT_W(CNT_W), .SQ_W(SQ_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (vld[STG_MEMWB]),
    .squashed_n (squashed_n),
    .commit_cnt (commit_cnt_o),
    .lost_cnt   (lost_cnt_o)
  );

  generate
    for (genvar s = 0; s < N_SQUASH; s++) begin : g_squash
      assign squash_o[s] = redirect;
    end
  endgenerate

  assign pc_o          = pc;
  assign pc_sel_o      = pc_sel;
  assign redirect_o    = redirect;
  assign redirect_pc_o = redirect_pc;
  assign stage_vld_o   = vld;

  AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect); // R4
  AST_REDIR_OVER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && stall_i) |=> (pc_o == $past(redirect_pc_o) && stage_vld_o[2:0] == 3'b000)); // R8
  AST_LOST_ONLY_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |=> $stable(lost_cnt_o)); // R9
  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (pc_o == '0 && stage_vld_o == '0 && commit_cnt_o == '0)); // R1

endmodule

// File: tb/test_bsq_redirect_ctl.sv
module test_bsq_redirect_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0;
  logic        stall = 1'b0;
  logic        dec_beq = 1'b0;
  logic [7:0]  dec_off = '0;
  logic        ex_equal = 1'b0;
  logic [15:0] pc;
  logic [1:0]  pc_sel;
  logic        redirect;
  logic [15:0] redirect_pc;
  logic [2:0]  squash;
  logic [15:0] ex_target;
  logic [3:0]  stage_vld;
  logic [31:0] commit_cnt;
  logic [31:0] lost_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  bsq_redirect_ctl i_bsq_redirect_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fetch_req_i   (fetch_req),
    .stall_i       (stall),
    .dec_beq_i     (dec_beq),
    .dec_off_i     (dec_off),
    .ex_equal_i    (ex_equal),
    .pc_o          (pc),
    .pc_sel_o      (pc_sel),
    .redirect_o    (redirect),
    .redirect_pc_o (redirect_pc),
    .squash_o      (squash),
    .ex_target_o   (ex_target),
    .stage_vld_o   (stage_vld),
    .commit_cnt_o  (commit_cnt),
    .lost_cnt_o    (lost_cnt)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Target by the rule: address + 1 + signed offset, 16-bit wrap
  function automatic logic [31:0] tgt(input int addr, input int off);
    return 32'((addr + 1 + off) & 16'hFFFF);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; fetch_req = 0; stall = 0; dec_beq = 0; dec_off = 0; ex_equal = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one cycle's inputs after the falling edge; caller checks before the rising edge
  task automatic cyc(input logic f, input logic s, input logic b,
                     input logic [7:0] o, input logic e);
    @(negedge clk);
    fetch_req = f; stall = s; dec_beq = b; dec_off = o; ex_equal = e;
    #2;
  endtask

  task automatic t_reset();
    do_reset();
    #2;
    check("R1", "pc", 32'(pc), 0);
    check("R1", "stage_vld", 32'(stage_vld), 0);
    check("R1", "commit_cnt", commit_cnt, 0);
    check("R1", "lost_cnt", lost_cnt, 0);
  endtask

  task automatic t_not_taken();
    do_reset();
    cyc(1, 0, 0, 8'd0, 0);            // cycle 1: fetch branch at 0
    check("R2", "pc_sel seq", 32'(pc_sel), 0);
    cyc(1, 0, 1, 8'd4, 0);            // cycle 2: branch in decode
    check("R2", "pc after fetch", 32'(pc), 1);
    check("R2", "ifid valid", 32'(stage_vld[0]), 1);
    cyc(1, 0, 0, 8'd0, 0);            // cycle 3: branch in execute, not equal
    check("R3", "ex_target", 32'(ex_target), tgt(0, 4));
    cyc(0, 0, 0, 8'd0, 0);            // cycle 4: branch in memory
    check("R5", "no redirect", 32'(redirect), 0);
    cyc(0, 0, 0, 8'd0, 0);
    cyc(0, 0, 0, 8'd0, 0);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 6
    check("R5", "commit after 6 edges", commit_cnt, 2);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 7
    check("R5", "commit after 7 edges", commit_cnt, 3);
    check("R9", "no lost", lost_cnt, 0);
  endtask

  task automatic t_taken();
    do_reset();
    cyc(1, 0, 0, 8'd0, 0);
    cyc(1, 0, 1, 8'd5, 0);
    cyc(1, 0, 0, 8'd0, 1);            // equal in execute
    check("R3", "ex_target", 32'(ex_target), tgt(0, 5));
    cyc(1, 0, 0, 8'd0, 0);            // cycle 4: redirect
    check("R4", "redirect", 32'(redirect), 1);
    check("R3", "redirect_pc", 32'(redirect_pc), tgt(0, 5));
    check("R4", "squash", 32'(squash), 7);
    check("R4", "pc_sel redir", 32'(pc_sel), 2);
    check("R4", "stage_vld before", 32'(stage_vld), 32'h7);
    cyc(1, 0, 0, 8'd0, 0);            // after edge 4
    check("R4", "pc target", 32'(pc), tgt(0, 5));
    check("R4", "stage_vld after", 32'(stage_vld), 32'h8);
    check("R4", "redirect dropped", 32'(redirect), 0);
    check("R9", "lost count", lost_cnt, 3);
    cyc(1, 0, 0, 8'd0, 0);
    check("R9", "branch committed", commit_cnt, 1);
    cyc(0, 0, 0, 8'd0, 0);
    cyc(0, 0, 0, 8'd0, 0);
    cyc(0, 0, 0, 8'd0, 0);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 9
    check("R6", "commit after 9 edges", commit_cnt, 2);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 10
    check("R6", "commit after 10 edges", commit_cnt, 3);
    check("R6", "lost unchanged", lost_cnt, 3);
  endtask

  task automatic t_stall();
    do_reset();
    cyc(1, 0, 0, 8'd0, 0);
    cyc(1, 0, 0, 8'd0, 0);
    cyc(1, 0, 0, 8'd0, 0);
    cyc(1, 1, 0, 8'd0, 0);            // cycle 4: stall
    check("R7", "pc_sel hold", 32'(pc_sel), 1);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 4
    check("R7", "pc held", 32'(pc), 3);
    check("R7", "bubble pattern", 32'(stage_vld), 32'hB);
    check("R10", "pc_sel idle", 32'(pc_sel), 1);
    cyc(0, 0, 0, 8'd0, 0);            // after edge 5
    check("R10", "pc idle", 32'(pc), 3);
    check("R10", "no fetch entered", 32'(stage_vld), 32'h6);
  endtask

  task automatic t_redir_stall();
    do_reset();
    cyc(1, 0, 0, 8'd0, 0);
    cyc(1, 0, 1, 8'hFD, 0);           // offset -3
    cyc(1, 0, 0, 8'd0, 1);
    check("R3", "negative offset target", 32'(ex_target), tgt(0, -3));
    cyc(1, 1, 0, 8'd0, 0);            // redirect plus stall
    check("R8", "pc_sel redir", 32'(pc_sel), 2);
    check("R8", "redirect", 32'(redirect), 1);
    cyc(0, 0, 0, 8'd0, 0);
    check("R8", "pc target", 32'(pc), tgt(0, -3));
    check("R8", "stage_vld", 32'(stage_vld), 32'h8);
    check("R9", "lost count", lost_cnt, 3);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_not_taken();
    t_taken();
    t_stall();
    t_redir_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule